// File: doc/BRIEF.md
# Floating-Point to Signed Word Converter

This block turns an already-unpacked double-precision operand into a signed 32-bit integer under one of four rounding modes. The operand arrives as a class code, a sign bit, a signed unbiased exponent and a 56-bit mantissa whose leading one sits at bit 55. The three bits below the 53-bit fraction are guard bits from earlier arithmetic. The result is always a legal signed word: values that do not fit, along with infinities and NaNs, clamp to the largest or smallest representable integer according to the sign.

Magnitudes below one bypass the shifter entirely and are settled by the rounding mode and sign alone. In-range values are aligned by a right shift of (55 − exponent), and the bits shifted out drive a rounding increment. The rounded magnitude is then tested for overflow into bit 31 and negated for negative inputs. One register stage sits between the inputs and the result. `out_valid` pulses one clock after `in_valid`, and the result holds between conversions.

Top module: `fti_conv`

## Requirements
- R1: Class code 2 (NaN) or 3 (infinity) yields 0x7FFFFFFF for sign 0 and 0x80000000 for sign 1.
- R2: Class code 1 (zero) yields 0 regardless of sign, exponent, mantissa and mode.
- R3: For class code 0 (normal), an exponent of 31 or more saturates to 0x7FFFFFFF (sign 0) or 0x80000000 (sign 1).
- R4: For a normal operand with negative exponent in mode 0 (nearest), the result is 0 if the exponent is −2 or lower. For an exponent of −1 it is +1 for sign 0 and −1 (0xFFFFFFFF) for sign 1.
- R5: For a normal operand with negative exponent, mode 1 (toward zero) gives 0. Mode 2 (toward +inf) gives 1 for sign 0 and 0 for sign 1. Mode 3 (toward −inf) gives −1 for sign 1 and 0 for sign 0.
- R6: For exponents 0 to 30, the magnitude is the mantissa shifted right by (55 − exponent). Mode 1 never adds an increment, so values that are exact or truncated come out unchanged.
- R7: In mode 0, the magnitude is incremented when the highest discarded bit, bit (54 − exponent), is set. Ties therefore round away from zero.
- R8: In mode 2, the magnitude is incremented when any discarded bit is set and the sign is 0. In mode 3, the same holds when the sign is 1.
- R9: If the rounded magnitude has bit 31 set, the result saturates by sign. Otherwise it is the magnitude, two's-complement negated when the sign is 1.
- R10: `out_valid` is 1 exactly one clock after a cycle with `in_valid` high and 0 otherwise. `out_int` changes only one clock after an accepted input. Reset clears both to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| in_class | input | 2 | 0 normal, 1 zero, 2 NaN, 3 infinity |
| in_sign | input | 1 | Operand sign, 1 is negative |
| in_exp | input | 12 | Signed unbiased exponent |
| in_mant | input | 56 | Mantissa, leading one at bit 55 |
| in_rmode | input | 2 | 0 nearest, 1 toward zero, 2 toward +inf, 3 toward −inf |
| out_valid | output | 1 | Result strobe |
| out_int | output | 32 | Saturated signed result |

## Verification
The bench targets the edges of the exponent range: −1 against −2 in nearest mode, 30 against 31 at the saturation threshold, and exponents up to 33. An off-by-one threshold shows up at exactly those points as a wrong 0/±1 or a wrapped value. A 1.5/1.25 family of operands separates the half-way increment from the sticky-only increment, so a design that picks the wrong discard bit, or rounds toward the wrong infinity, gives results off by one. An all-ones mantissa at exponent 30 rounds up into bit 31 and must clamp rather than wrap to a negative number. A full sweep in every mode is compared against a model written from the requirements.

// File: rtl/fti_pkg.sv
package fti_pkg;

    typedef enum logic [1:0] {
        CLS_NORM = 2'd0,
        CLS_ZERO = 2'd1,
        CLS_NAN  = 2'd2,
        CLS_INF  = 2'd3
    } num_class_e;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_UP   = 2'd2,
        RM_DOWN = 2'd3
    } rmode_e;

    // which datapath decides the result
    typedef enum logic [1:0] {
        PATH_FIXED = 2'd0,
        PATH_SAT   = 2'd1,
        PATH_SHIFT = 2'd2
    } path_e;

endpackage

// File: rtl/fti_classify.sv
module fti_classify
    import fti_pkg::*;
#(
    parameter int EXP_W = 12,
    parameter int INT_W = 32
) (
    input  logic [1:0]              cls,
    input  logic                    sign,
    input  logic signed [EXP_W-1:0] exp_in,
    input  logic [1:0]              rmode,
    output path_e                   path,
    output logic [INT_W-1:0]        fixed_val
);
    localparam int SAT_EXP = INT_W - 1;
    localparam logic [INT_W-1:0] ONE   = INT_W'(1);
    localparam logic [INT_W-1:0] MINUS = '1;

    logic [INT_W-1:0] small_val;

    // result for normal operands with magnitude below one
    always_comb begin
        small_val = '0;
        unique case (rmode_e'(rmode))
            RM_NEAR: small_val = (int'(exp_in) == -1) ? (sign ? MINUS : ONE) : '0;
            RM_ZERO: small_val = '0;
            RM_UP:   small_val = sign ? '0 : ONE;
            RM_DOWN: small_val = sign ? MINUS : '0;
            default: small_val = '0;
        endcase
    end

    always_comb begin
        path      = PATH_FIXED;
        fixed_val = '0;
        unique case (num_class_e'(cls))
            CLS_NORM: begin
                if (int'(exp_in) >= SAT_EXP) begin
                    path = PATH_SAT;
                end else if (int'(exp_in) < 0) begin
                    path      = PATH_FIXED;
                    fixed_val = small_val;
                end else begin
                    path = PATH_SHIFT;
                end
            end
            CLS_ZERO: begin
                path      = PATH_FIXED;
                fixed_val = '0;
            end
            default: path = PATH_SAT;
        endcase
    end
endmodule

// File: rtl/fti_align.sv
module fti_align #(
    parameter int EXP_W  = 12,
    parameter int MANT_W = 56,
    parameter int INT_W  = 32
) (
    input  logic [MANT_W-1:0]       mant,
    input  logic signed [EXP_W-1:0] exp_in,
    output logic [INT_W:0]          mag,
    output logic                    any_drop,
    output logic                    top_drop
);
    localparam int HID  = MANT_W - 1;
    localparam int SH_W = $clog2(MANT_W + 1);
    localparam int MAXE = INT_W - 2;

    logic [SH_W-1:0]   sh;
    logic [MANT_W-1:0] drop_mask;
    logic [MANT_W-1:0] shifted;

    // shift distance, clamped outside the in-range window
    always_comb begin
        if (int'(exp_in) >= 0 && int'(exp_in) <= MAXE)
            sh = SH_W'(HID - int'(exp_in));
        else
            sh = SH_W'(HID);
    end

    // one mask bit per mantissa position below the binary point
    for (genvar i = 0; i < MANT_W; i++) begin : g_mask
        assign drop_mask[i] = (SH_W'(i) < sh);
    end

    assign shifted  = mant >> sh;
    assign mag      = shifted[INT_W:0];
    assign any_drop = |(mant & drop_mask);
    assign top_drop = (sh != '0) ? mant[sh - 1'b1] : 1'b0;
endmodule

// File: rtl/fti_round.sv
module fti_round
    import fti_pkg::*;
(
    input  logic [1:0] rmode,
    input  logic       sign,
    input  logic       any_drop,
    input  logic       top_drop,
    output logic       inc
);
    always_comb begin
        unique case (rmode_e'(rmode))
            RM_NEAR: inc = any_drop & top_drop;
            RM_ZERO: inc = 1'b0;
            RM_UP:   inc = any_drop & ~sign;
            RM_DOWN: inc = any_drop & sign;
            default: inc = 1'b0;
        endcase
    end
endmodule

// File: rtl/fti_conv.sv
module fti_conv
    import fti_pkg::*;
#(
    parameter int EXP_W  = 12,
    parameter int MANT_W = 56,
    parameter int INT_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [1:0]              in_class,
    input  logic                    in_sign,
    input  logic signed [EXP_W-1:0] in_exp,
    input  logic [MANT_W-1:0]       in_mant,
    input  logic [1:0]              in_rmode,
    output logic                    out_valid,
    output logic [INT_W-1:0]        out_int
);
    localparam logic [INT_W-1:0] POS_LIM = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] NEG_LIM = {1'b1, {(INT_W-1){1'b0}}};

    typedef struct packed {
        logic             valid;
        logic [INT_W-1:0] result;
    } out_state_t;

    out_state_t state_d, state_q;

    path_e            path;
    logic [INT_W-1:0] fixed_val;
    logic [INT_W:0]   mag_raw;
    logic             any_drop;
    logic             top_drop;
    logic             inc;
    logic [INT_W:0]   mag_rnd;
    logic [INT_W-1:0] sat_val;
    logic [INT_W-1:0] conv_val;

    fti_classify #(.EXP_W(EXP_W), .INT_W(INT_W)) u_classify (
        .cls       (in_class),
        .sign      (in_sign),
        .exp_in    (in_exp),
        .rmode     (in_rmode),
        .path      (path),
        .fixed_val (fixed_val)
    );

    fti_align #(.EXP_W(EXP_W), .MANT_W(MANT_W), .INT_W(INT_W)) u_align (
        .mant     (in_mant),
        .exp_in   (in_exp),
        .mag      (mag_raw),
        .any_drop (any_drop),
        .top_drop (top_drop)
    );

    fti_round u_round (
        .rmode    (in_rmode),
        .sign     (in_sign),
        .any_drop (any_drop),
        .top_drop (top_drop),
        .inc      (inc)
    );

    always_comb begin
        sat_val = in_sign ? NEG_LIM : POS_LIM;
        mag_rnd = mag_raw + {{INT_W{1'b0}}, inc};
        unique case (path)
            PATH_FIXED: conv_val = fixed_val;
            PATH_SAT:   conv_val = sat_val;
            default: begin
                if (mag_rnd[INT_W] | mag_rnd[INT_W-1])
                    conv_val = sat_val;
                else if (in_sign)
                    conv_val = ~mag_rnd[INT_W-1:0] + 1'b1;
                else
                    conv_val = mag_rnd[INT_W-1:0];
            end
        endcase

        state_d.valid  = in_valid;
        state_d.result = in_valid ? conv_val : state_q.result;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid = state_q.valid;
    assign out_int   = state_q.result;
endmodule

// File: rtl/fti_conv_chk.sv
module fti_conv_chk #(
    parameter int EXP_W  = 12,
    parameter int MANT_W = 56,
    parameter int INT_W  = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [1:0]              in_class,
    input logic                    in_sign,
    input logic signed [EXP_W-1:0] in_exp,
    input logic [1:0]              in_rmode,
    input logic                    out_valid,
    input logic [INT_W-1:0]        out_int
);
    localparam logic [INT_W-1:0] POS_LIM = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] NEG_LIM = {1'b1, {(INT_W-1){1'b0}}};

    a_r1_special_sat: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_class[1] |=> out_int == ($past(in_sign) ? NEG_LIM : POS_LIM));

    a_r2_zero_class: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_class == 2'd1 |=> out_int == '0);

    a_r3_big_exp: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_class == 2'd0 && int'(in_exp) >= INT_W - 1
        |=> out_int == ($past(in_sign) ? NEG_LIM : POS_LIM));

    a_r5_toward_zero_small: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_class == 2'd0 && int'(in_exp) < 0 && in_rmode == 2'd1
        |=> out_int == '0);

    a_r9_positive_sign: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_sign |=> !out_int[INT_W-1]);

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r10_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_int));
endmodule

bind fti_conv fti_conv_chk #(.EXP_W(EXP_W), .MANT_W(MANT_W), .INT_W(INT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_class  (in_class),
    .in_sign   (in_sign),
    .in_exp    (in_exp),
    .in_rmode  (in_rmode),
    .out_valid (out_valid),
    .out_int   (out_int)
);

// File: tb/fti_conv_bench.sv
module fti_conv_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_class = '0;
    logic        in_sign = 1'b0;
    logic signed [11:0] in_exp = '0;
    logic [55:0] in_mant = '0;
    logic [1:0]  in_rmode = '0;
    logic        out_valid;
    logic [31:0] out_int;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [55:0] M_ONE   = 56'h80_0000_0000_0000;
    localparam logic [55:0] M_1P5   = 56'hC0_0000_0000_0000;
    localparam logic [55:0] M_1P25  = 56'hA0_0000_0000_0000;
    localparam logic [55:0] M_ONES  = 56'hFF_FFFF_FFFF_FFFF;

    always #10 clk = ~clk;

    fti_conv u_fti_conv (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
        .in_rmode(in_rmode), .out_valid(out_valid), .out_int(out_int)
    );

    function automatic logic [31:0] sat_of(bit s);
        return s ? 32'h8000_0000 : 32'h7FFF_FFFF;
    endfunction

    // reference written from the requirements
    function automatic logic [31:0] ref_conv(int cls, bit s, int e, logic [55:0] m, int rm);
        logic [63:0] mag, disc;
        int sh;
        bit half, inc;
        if (cls >= 2) return sat_of(s);
        if (cls == 1) return 32'd0;
        if (e >= 31) return sat_of(s);
        if (e < 0) begin
            case (rm)
                0: return (e == -1) ? (s ? 32'hFFFF_FFFF : 32'd1) : 32'd0;
                1: return 32'd0;
                2: return s ? 32'd0 : 32'd1;
                default: return s ? 32'hFFFF_FFFF : 32'd0;
            endcase
        end
        sh   = 55 - e;
        mag  = {8'd0, m} >> sh;
        disc = {8'd0, m} & ((64'd1 << sh) - 64'd1);
        half = m[sh-1];
        case (rm)
            0: inc = half;
            1: inc = 1'b0;
            2: inc = (disc != 0) && !s;
            default: inc = (disc != 0) && s;
        endcase
        mag = mag + 64'(inc);
        if (mag[31] || mag[32]) return sat_of(s);
        return s ? (~mag[31:0] + 32'd1) : mag[31:0];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp_v);
        end
    endtask

    // drive one operand, return the registered result one clock later
    task automatic convert(int cls, bit s, int e, logic [55:0] m, int rm,
                           output logic [31:0] res, output logic vld);
        @(negedge clk);
        in_class = 2'(cls); in_sign = s; in_exp = 12'(e);
        in_mant = m; in_rmode = 2'(rm); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        res = out_int; vld = out_valid;
    endtask

    task automatic run_ref(string req, int cls, bit s, int e, logic [55:0] m, int rm);
        logic [31:0] r; logic v;
        convert(cls, s, e, m, rm, r, v);
        chk(req, r, ref_conv(cls, s, e, m, rm));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R10 reset valid", {31'd0, out_valid}, 32'd0);
        chk("R10 reset data", out_int, 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_specials();
        logic [31:0] r; logic v;
        convert(2, 0, 5, M_1P5, 0, r, v); chk("R1 nan pos", r, 32'h7FFF_FFFF);
        convert(2, 1, 5, M_1P5, 1, r, v); chk("R1 nan neg", r, 32'h8000_0000);
        convert(3, 0, 0, '0, 2, r, v);    chk("R1 inf pos", r, 32'h7FFF_FFFF);
        convert(3, 1, 0, '0, 3, r, v);    chk("R1 inf neg", r, 32'h8000_0000);
    endtask

    task automatic t_zero();
        logic [31:0] r; logic v;
        convert(1, 1, 12, M_ONES, 3, r, v); chk("R2 zero neg", r, 32'd0);
        convert(1, 0, 40, M_ONES, 2, r, v); chk("R2 zero pos", r, 32'd0);
    endtask

    task automatic t_big_exp();
        logic [31:0] r; logic v;
        convert(0, 0, 31, M_ONE, 1, r, v); chk("R3 e31 pos", r, 32'h7FFF_FFFF);
        convert(0, 1, 31, M_ONE, 1, r, v); chk("R3 e31 neg", r, 32'h8000_0000);
        convert(0, 0, 30, M_ONE, 1, r, v); chk("R3 e30 fits", r, 32'h4000_0000);
        convert(0, 1, 30, M_ONE, 1, r, v); chk("R3 e30 neg", r, 32'hC000_0000);
    endtask

    task automatic t_small_nearest();
        logic [31:0] r; logic v;
        convert(0, 0, -1, M_ONE, 0, r, v); chk("R4 e-1 pos", r, 32'd1);
        convert(0, 1, -1, M_ONE, 0, r, v); chk("R4 e-1 neg", r, 32'hFFFF_FFFF);
        convert(0, 0, -2, M_ONES, 0, r, v); chk("R4 e-2 pos", r, 32'd0);
        convert(0, 1, -2, M_ONES, 0, r, v); chk("R4 e-2 neg", r, 32'd0);
    endtask

    task automatic t_small_directed();
        logic [31:0] r; logic v;
        convert(0, 1, -1, M_ONES, 1, r, v); chk("R5 rz neg", r, 32'd0);
        convert(0, 0, -3, M_ONE, 2, r, v);  chk("R5 up pos", r, 32'd1);
        convert(0, 1, -3, M_ONE, 2, r, v);  chk("R5 up neg", r, 32'd0);
        convert(0, 1, -3, M_ONE, 3, r, v);  chk("R5 down neg", r, 32'hFFFF_FFFF);
        convert(0, 0, -3, M_ONE, 3, r, v);  chk("R5 down pos", r, 32'd0);
    endtask

    task automatic t_truncate();
        logic [31:0] r; logic v;
        convert(0, 0, 0, M_ONE, 1, r, v);  chk("R6 one", r, 32'd1);
        convert(0, 0, 1, M_1P5, 1, r, v);  chk("R6 three", r, 32'd3);
        convert(0, 1, 0, M_1P5, 1, r, v);  chk("R6 rz -1.5", r, 32'hFFFF_FFFF);
        convert(0, 0, 10, M_ONES, 1, r, v); chk("R6 rz 2047.x", r, 32'd2047);
    endtask

    task automatic t_nearest();
        logic [31:0] r; logic v;
        convert(0, 0, 0, M_1P5, 0, r, v);  chk("R7 1.5", r, 32'd2);
        convert(0, 1, 0, M_1P5, 0, r, v);  chk("R7 -1.5", r, 32'hFFFF_FFFE);
        convert(0, 0, 0, M_1P25, 0, r, v); chk("R7 1.25", r, 32'd1);
        convert(0, 0, 1, M_1P25, 0, r, v); chk("R7 2.5", r, 32'd3);
    endtask

    task automatic t_directed();
        logic [31:0] r; logic v;
        convert(0, 0, 0, M_1P25, 2, r, v); chk("R8 up +1.25", r, 32'd2);
        convert(0, 1, 0, M_1P25, 2, r, v); chk("R8 up -1.25", r, 32'hFFFF_FFFF);
        convert(0, 1, 0, M_1P25, 3, r, v); chk("R8 down -1.25", r, 32'hFFFF_FFFE);
        convert(0, 0, 0, M_1P25, 3, r, v); chk("R8 down +1.25", r, 32'd1);
        convert(0, 0, 2, M_ONE, 2, r, v);  chk("R8 up exact", r, 32'd4);
    endtask

    task automatic t_carry_sat();
        logic [31:0] r; logic v;
        convert(0, 0, 30, M_ONES, 0, r, v); chk("R9 carry pos", r, 32'h7FFF_FFFF);
        convert(0, 1, 30, M_ONES, 0, r, v); chk("R9 carry neg", r, 32'h8000_0000);
        convert(0, 0, 30, M_ONES, 2, r, v); chk("R9 carry up", r, 32'h7FFF_FFFF);
        convert(0, 1, 30, M_ONES, 1, r, v); chk("R9 no carry neg", r, 32'h8000_0001);
    endtask

    task automatic t_hold();
        logic [31:0] r; logic v;
        convert(0, 0, 4, M_ONE, 1, r, v);
        chk("R10 valid strobe", {31'd0, v}, 32'd1);
        chk("R10 data", r, 32'd16);
        in_class = 2'd3; in_sign = 1'b1; in_exp = 12'd7; in_mant = M_ONES;
        @(negedge clk);
        chk("R10 idle valid", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        chk("R10 held data", out_int, 32'd16);
    endtask

    task automatic t_sweep();
        for (int rm = 0; rm < 4; rm++) begin
            for (int e = -3; e <= 33; e++) begin
                for (int k = 0; k < 3; k++) begin
                    logic [55:0] m;
                    m = {1'b1, 23'($urandom), 32'($urandom)};
                    run_ref("R6 R7 R8 R9 sweep", 0, k[0], e, m, rm);
                end
            end
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_specials();
        t_zero();
        t_big_exp();
        t_small_nearest();
        t_small_directed();
        t_truncate();
        t_nearest();
        t_directed();
        t_carry_sat();
        t_hold();
        t_sweep();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule